// File: doc/BRIEF.md
# Multi-Mode 8-bit PWM Timer

This block is an 8-bit timer/counter that advances only on cycles where a clock-enable tick is high. A 3-bit mode selector chooses one of four counting behaviours: free-running count, clear-on-compare (CTC), fast PWM with a sawtooth count, and phase-correct PWM with a triangular up/down count. The mode also sets where the count turns round (TOP), when the two compare values take effect, and when the overflow flag is raised.

Two compare channels, A and B, each have a write buffer and an active value. Channel A can serve as TOP. Channel B drives a waveform pin through a 2-bit output-mode field. Three sticky flags report overflow and the two compare matches. Each flag is cleared by its own strobe.

The counter direction is held in a two-state machine. `ST_UP` moves to `ST_DOWN` when a phase-correct count reaches a non-zero TOP. `ST_DOWN` returns to `ST_UP` when the count reaches BOTTOM (0x00), or when the mode is no longer phase-correct. Every other transition keeps the current state.

Top module: `pwm_timer8`

## Requirements
- R1: While reset is low and just after it is released, the count is 0x00, all three flags are 0 and the pin is 0.
- R2: In mode 0 and in the reserved modes 4 and 6, each tick adds one to the count, with 0xFF wrapping to 0x00. On a cycle without a tick, the count does not change.
- R3: In mode 2 (CTC), TOP is the active compare A. A tick taken while the count equals compare A makes the next count 0x00.
- R4: In fast PWM, the count runs from 0x00 up to TOP and the following tick returns it to 0x00. Mode 3 uses TOP = 0xFF. Mode 7 uses TOP = compare A.
- R5: In phase-correct PWM, the count rises from 0x00 to TOP and then falls back to 0x00. TOP and BOTTOM each last exactly one tick. Mode 1 uses TOP = 0xFF. Mode 5 uses TOP = compare A.
- R6: In modes 0, 2, 4 and 6, a compare write updates the active value at once. In modes 1, 3, 5 and 7, the write goes into the buffer only. The active value is loaded from the buffer on a tick taken while the count equals TOP.
- R7: The overflow flag is set by a tick taken at the following count: 0xFF in modes 0, 2, 4 and 6; TOP in fast PWM; 0x00 in phase-correct PWM.
- R8: A compare flag is set by a tick taken while the count equals that channel's active compare value. A clear strobe on a cycle with no setting event drives the flag to 0.
- R9: In modes 0, 2, 4 and 6, a tick that matches compare B changes the pin according to the output-mode code: 01 toggles it, 10 clears it, 11 sets it.
- R10: In fast PWM, code 10 clears the pin on a B match and sets it on a tick at 0x00. Code 11 does the opposite. When both happen on the same tick, the match wins.
- R11: In phase-correct PWM, code 10 clears the pin on a B match while counting up and sets it on a match while counting down. Code 11 does the opposite. A tick taken at 0x00 counts as counting up.
- R12: When compare B equals TOP and the high output-mode bit is set, the B match has no effect on the pin. In fast PWM, the pin is instead driven only at BOTTOM. In phase-correct PWM, code 10 sets the pin at TOP and code 11 clears it there.
- R13: Output-mode code 00, and code 01 in any PWM mode, hold the pin output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable |
| wgm | input | 3 | Mode selector |
| com_b | input | 2 | Output-mode code for pin B |
| cmp_a_wr | input | 1 | Write strobe for compare A |
| cmp_b_wr | input | 1 | Write strobe for compare B |
| cmp_wdata | input | 8 | Compare write data |
| ovf_clr | input | 1 | Overflow flag clear |
| cfa_clr | input | 1 | Compare A flag clear |
| cfb_clr | input | 1 | Compare B flag clear |
| count | output | 8 | Current count |
| pin_b | output | 1 | Channel B waveform |
| ovf_flag | output | 1 | Overflow flag |
| cfa_flag | output | 1 | Compare A match flag |
| cfb_flag | output | 1 | Compare B match flag |

## Verification
The bench builds the timer with its default 8-bit count width. At that width a full 0x00–0xFF sweep, and a complete phase-correct triangle, each take only a few hundred ticks. This makes it cheap to run every mode through several whole periods. It also brings the extreme compare values 0x00 and 0xFF, and a compare A used as a small TOP, within reach in a single run.

// File: rtl/pwm_timer8_pkg.sv
package pwm_timer8_pkg;

    typedef enum logic [1:0] {
        KIND_NORMAL,
        KIND_CTC,
        KIND_FAST,
        KIND_PHASE
    } cnt_kind_e;

    typedef enum logic {
        ST_UP,
        ST_DOWN
    } dir_state_e;

    function automatic cnt_kind_e decode_kind(input logic [2:0] m);
        cnt_kind_e k;
        unique case (m)
            3'd1, 3'd5: k = KIND_PHASE;
            3'd2:       k = KIND_CTC;
            3'd3, 3'd7: k = KIND_FAST;
            default:    k = KIND_NORMAL;
        endcase
        return k;
    endfunction

    function automatic logic top_is_cmp_a(input logic [2:0] m);
        return (m == 3'd2) || (m == 3'd5) || (m == 3'd7);
    endfunction

endpackage

// File: rtl/pwm_cnt_fsm.sv
module pwm_cnt_fsm
    import pwm_timer8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  cnt_kind_e    kind,
    input  logic [W-1:0] top,
    output logic [W-1:0] count,
    output logic         at_top,
    output logic         at_bottom,
    output logic         dir_up
);
    localparam logic [W-1:0] ONE = W'(1);

    dir_state_e   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_UP;
        end else if (tick) begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UP:   if (kind == KIND_PHASE && at_top && top != '0) state_d = ST_DOWN;
            ST_DOWN: if (kind != KIND_PHASE || at_bottom) state_d = ST_UP;
        endcase
    end

    always_comb begin
        cnt_d = cnt_q + ONE;
        unique case (kind)
            KIND_PHASE: begin
                if (state_q == ST_UP) begin
                    if (at_top) cnt_d = (top == '0) ? '0 : cnt_q - ONE;
                end else begin
                    cnt_d = at_bottom ? ((top == '0) ? '0 : ONE) : cnt_q - ONE;
                end
            end
            KIND_FAST, KIND_CTC: if (at_top) cnt_d = '0;
            KIND_NORMAL: cnt_d = cnt_q + ONE;
        endcase
    end

    always_comb begin
        count     = cnt_q;
        at_top    = (cnt_q == top);
        at_bottom = (cnt_q == '0);
        dir_up    = (state_q == ST_UP) || at_bottom;
    end

endmodule

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank #(
    parameter int W = 8,
    parameter int N = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        wr,
    input  logic [W-1:0]        wdata,
    input  logic                immediate,
    input  logic                load,
    output logic [N-1:0][W-1:0] act
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        logic [W-1:0] buf_q, act_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                buf_q <= '0;
                act_q <= '0;
            end else begin
                if (wr[i]) buf_q <= wdata;
                if (wr[i] && immediate) act_q <= wdata;
                else if (load) act_q <= buf_q;
            end
        end

        assign act[i] = act_q;
    end

endmodule

// File: rtl/pwm_wave_out.sv
module pwm_wave_out
    import pwm_timer8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  cnt_kind_e    kind,
    input  logic [1:0]   com,
    input  logic [W-1:0] count,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] top,
    input  logic         at_top,
    input  logic         at_bottom,
    input  logic         dir_up,
    output logic         pin
);
    logic q, q_d, match, special, connected;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_d;
    end

    always_comb begin
        match   = (count == cmp);
        special = (cmp == top) && com[1];
        q_d     = q;
        if (tick) begin
            unique case (kind)
                KIND_NORMAL, KIND_CTC: begin
                    if (match) begin
                        unique case (com)
                            2'b01:   q_d = ~q;
                            2'b10:   q_d = 1'b0;
                            2'b11:   q_d = 1'b1;
                            default: q_d = q;
                        endcase
                    end
                end
                KIND_FAST: begin
                    if (com[1]) begin
                        if (match && !special) q_d = com[0];
                        else if (at_bottom)    q_d = ~com[0];
                    end
                end
                KIND_PHASE: begin
                    if (com[1]) begin
                        if (special) begin
                            if (at_top) q_d = ~com[0];
                        end else if (match) begin
                            q_d = dir_up ? com[0] : ~com[0];
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        connected = com[1] || (com == 2'b01 && (kind == KIND_NORMAL || kind == KIND_CTC));
        pin       = q && connected;
    end

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
    import pwm_timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [2:0]       wgm,
    input  logic [1:0]       com_b,
    input  logic             cmp_a_wr,
    input  logic             cmp_b_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             ovf_clr,
    input  logic             cfa_clr,
    input  logic             cfb_clr,
    output logic [CNT_W-1:0] count,
    output logic             pin_b,
    output logic             ovf_flag,
    output logic             cfa_flag,
    output logic             cfb_flag
);
    localparam int N_CMP = 2;

    cnt_kind_e                      kind;
    logic [CNT_W-1:0]               top, cmp_a_act;
    logic [N_CMP-1:0][CNT_W-1:0]    act;
    logic                           at_top, at_bottom, dir_up, ovf_evt, pwm;
    logic [N_CMP-1:0]               flag_q, flag_clr;

    assign kind      = decode_kind(wgm);
    assign pwm       = (kind == KIND_FAST) || (kind == KIND_PHASE);
    assign cmp_a_act = act[0];
    assign top       = top_is_cmp_a(wgm) ? cmp_a_act : '1;

    pwm_cnt_fsm #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .kind(kind), .top(top),
        .count(count), .at_top(at_top), .at_bottom(at_bottom), .dir_up(dir_up)
    );

    pwm_cmp_bank #(.W(CNT_W), .N(N_CMP)) u_cmp (
        .clk(clk), .rst_n(rst_n), .wr({cmp_b_wr, cmp_a_wr}), .wdata(cmp_wdata),
        .immediate(!pwm), .load(tick && at_top && pwm), .act(act)
    );

    pwm_wave_out #(.W(CNT_W)) u_wave (
        .clk(clk), .rst_n(rst_n), .tick(tick), .kind(kind), .com(com_b),
        .count(count), .cmp(act[1]), .top(top), .at_top(at_top),
        .at_bottom(at_bottom), .dir_up(dir_up), .pin(pin_b)
    );

    always_comb begin
        unique case (kind)
            KIND_NORMAL, KIND_CTC: ovf_evt = (count == '1);
            KIND_FAST:             ovf_evt = at_top;
            KIND_PHASE:            ovf_evt = at_bottom;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                ovf_flag <= 1'b0;
        else if (tick && ovf_evt)  ovf_flag <= 1'b1;
        else if (ovf_clr)          ovf_flag <= 1'b0;
    end

    assign flag_clr = {cfb_clr, cfa_clr};

    for (genvar i = 0; i < N_CMP; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)                          flag_q[i] <= 1'b0;
            else if (tick && count == act[i])    flag_q[i] <= 1'b1;
            else if (flag_clr[i])                flag_q[i] <= 1'b0;
        end
    end

    assign cfa_flag = flag_q[0];
    assign cfb_flag = flag_q[1];

endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic [2:0]   wgm,
    input logic [W-1:0] count,
    input logic [W-1:0] cmp_a,
    input logic         ovf_flag,
    input logic         cfa_flag,
    input logic         cfa_clr
);
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));

    a_r2_normal_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wgm == 3'd0) |=> count == W'($past(count) + 1'b1));

    a_r3_ctc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wgm == 3'd2 && count == cmp_a) |=> count == '0);

    a_r7_ovf_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && wgm == 3'd0 && count == '1) |=> ovf_flag);

    a_r8_cfa_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cfa_clr && !(tick && count == cmp_a)) |=> !cfa_flag);

endmodule

bind pwm_timer8 pwm_timer8_chk #(.W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wgm(wgm), .count(count),
    .cmp_a(cmp_a_act), .ovf_flag(ovf_flag), .cfa_flag(cfa_flag), .cfa_clr(cfa_clr)
);

// File: tb/test_pwm_timer8.sv
`timescale 1ns/1ps
module test_pwm_timer8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] wgm = 3'd0;
    logic [1:0] com_b = 2'b00;
    logic       cmp_a_wr = 1'b0, cmp_b_wr = 1'b0;
    logic [7:0] cmp_wdata = 8'h00;
    logic       ovf_clr = 1'b0, cfa_clr = 1'b0, cfb_clr = 1'b0;
    logic [7:0] count;
    logic       pin_b, ovf_flag, cfa_flag, cfb_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // model state
    logic [7:0] m_cnt, m_acta, m_actb, m_bufa, m_bufb;
    logic       m_up, m_q, m_ovf, m_cfa, m_cfb;

    always #4 clk = ~clk;

    pwm_timer8 i_pwm_timer8 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wgm(wgm), .com_b(com_b),
        .cmp_a_wr(cmp_a_wr), .cmp_b_wr(cmp_b_wr), .cmp_wdata(cmp_wdata),
        .ovf_clr(ovf_clr), .cfa_clr(cfa_clr), .cfb_clr(cfb_clr),
        .count(count), .pin_b(pin_b), .ovf_flag(ovf_flag),
        .cfa_flag(cfa_flag), .cfb_flag(cfb_flag)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // 0 normal, 1 ctc, 2 fast, 3 phase
    function automatic int kind_of(input logic [2:0] m);
        if (m == 3'd1 || m == 3'd5) return 3;
        if (m == 3'd2) return 1;
        if (m == 3'd3 || m == 3'd7) return 2;
        return 0;
    endfunction

    function automatic logic exp_pin();
        int k = kind_of(wgm);
        logic conn = com_b[1] || (com_b == 2'b01 && k < 2);
        return m_q && conn;
    endfunction

    task automatic compare_all(input string tag_cnt, input string tag_pin);
        chk(tag_cnt, "count", count, m_cnt);
        chk("R7", "ovf_flag", ovf_flag, m_ovf);
        chk("R8", "cfa_flag", cfa_flag, m_cfa);
        chk("R8", "cfb_flag", cfb_flag, m_cfb);
        chk(tag_pin, "pin_b", pin_b, exp_pin());
    endtask

    task automatic do_tick(input string tag_cnt, input string tag_pin);
        int k = kind_of(wgm);
        logic [7:0] top = (wgm == 3'd2 || wgm == 3'd5 || wgm == 3'd7) ? m_acta : 8'hFF;
        logic at_top = (m_cnt == top);
        logic at_bot = (m_cnt == 8'h00);
        logic dirup = m_up || at_bot;
        logic match = (m_cnt == m_actb);
        logic spec = (m_actb == top) && com_b[1];
        logic [7:0] n_cnt;
        logic n_up = m_up;
        logic n_q = m_q;
        // flags
        if ((k < 2 && m_cnt == 8'hFF) || (k == 2 && at_top) || (k == 3 && at_bot)) m_ovf = 1'b1;
        if (m_cnt == m_acta) m_cfa = 1'b1;
        if (m_cnt == m_actb) m_cfb = 1'b1;
        // pin
        if (k < 2) begin
            if (match) begin
                if (com_b == 2'b01) n_q = ~m_q;
                else if (com_b == 2'b10) n_q = 1'b0;
                else if (com_b == 2'b11) n_q = 1'b1;
            end
        end else if (k == 2) begin
            if (com_b[1]) begin
                if (match && !spec) n_q = com_b[0];
                else if (at_bot) n_q = ~com_b[0];
            end
        end else begin
            if (com_b[1]) begin
                if (spec) begin
                    if (at_top) n_q = ~com_b[0];
                end else if (match) n_q = dirup ? com_b[0] : ~com_b[0];
            end
        end
        // count
        if (k == 3) begin
            if (m_up) begin
                if (at_top) begin
                    n_cnt = (top == 0) ? 8'h00 : m_cnt - 8'h01;
                    if (top != 0) n_up = 1'b0;
                end else n_cnt = m_cnt + 8'h01;
            end else begin
                if (at_bot) begin
                    n_cnt = (top == 0) ? 8'h00 : 8'h01;
                    n_up = 1'b1;
                end else n_cnt = m_cnt - 8'h01;
            end
        end else begin
            n_up = 1'b1;
            n_cnt = ((k == 1 || k == 2) && at_top) ? 8'h00 : m_cnt + 8'h01;
        end
        if (k >= 2 && at_top) begin
            m_acta = m_bufa;
            m_actb = m_bufb;
        end
        m_cnt = n_cnt; m_up = n_up; m_q = n_q;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        compare_all(tag_cnt, tag_pin);
    endtask

    task automatic run(input int n, input string tag_cnt, input string tag_pin);
        for (int i = 0; i < n; i++) do_tick(tag_cnt, tag_pin);
    endtask

    task automatic wr_cmp(input bit ch_b, input logic [7:0] val);
        cmp_wdata = val;
        if (ch_b) cmp_b_wr = 1'b1; else cmp_a_wr = 1'b1;
        if (ch_b) m_bufb = val; else m_bufa = val;
        if (kind_of(wgm) < 2) begin
            if (ch_b) m_actb = val; else m_acta = val;
        end
        @(negedge clk);
        cmp_a_wr = 1'b0; cmp_b_wr = 1'b0;
    endtask

    task automatic clr_flags();
        ovf_clr = 1'b1; cfa_clr = 1'b1; cfb_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0; cfa_clr = 1'b0; cfb_clr = 1'b0;
        m_ovf = 0; m_cfa = 0; m_cfb = 0;
        chk("R8", "ovf after clear", ovf_flag, 0);
        chk("R8", "cfa after clear", cfa_flag, 0);
        chk("R8", "cfb after clear", cfb_flag, 0);
    endtask

    task automatic reset_dut(input logic [2:0] mode, input logic [1:0] com);
        rst_n = 1'b0; wgm = mode; com_b = com;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 0; m_acta = 0; m_actb = 0; m_bufa = 0; m_bufb = 0;
        m_up = 1; m_q = 0; m_ovf = 0; m_cfa = 0; m_cfb = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "count in reset", count, 0);
        chk("R1", "ovf in reset", ovf_flag, 0);
        chk("R1", "cfa in reset", cfa_flag, 0);
        chk("R1", "cfb in reset", cfb_flag, 0);
        chk("R1", "pin in reset", pin_b, 0);
        reset_dut(3'd0, 2'b00);
        compare_all("R1", "R1");
    endtask

    task automatic t_normal();
        logic [7:0] held;
        reset_dut(3'd0, 2'b01);
        wr_cmp(1'b1, 8'h80);
        wr_cmp(1'b0, 8'h20);
        run(600, "R2", "R9");
        held = count;
        repeat (4) @(negedge clk);
        chk("R2", "count idle hold", count, held);
        clr_flags();
        com_b = 2'b10; run(300, "R2", "R9");
        com_b = 2'b11; run(300, "R2", "R9");
        wr_cmp(1'b1, m_cnt + 8'h02);
        run(3, "R6", "R6");
        com_b = 2'b00; run(20, "R2", "R13");
    endtask

    task automatic t_ctc();
        reset_dut(3'd2, 2'b01);
        wr_cmp(1'b0, 8'h10);
        wr_cmp(1'b1, 8'h08);
        run(60, "R3", "R9");
        wr_cmp(1'b0, 8'h05);
        run(30, "R6", "R9");
        wr_cmp(1'b0, 8'h00);
        run(10, "R3", "R9");
    endtask

    task automatic t_fast();
        reset_dut(3'd3, 2'b10);
        wr_cmp(1'b1, 8'h40);
        run(600, "R4", "R10");
        wr_cmp(1'b1, 8'h00);
        run(600, "R6", "R10");
        wr_cmp(1'b1, 8'hFF);
        run(600, "R4", "R12");
        com_b = 2'b11;
        wr_cmp(1'b1, 8'h80);
        run(600, "R4", "R10");
        com_b = 2'b01;
        run(50, "R4", "R13");
        reset_dut(3'd7, 2'b10);
        wr_cmp(1'b0, 8'h30);
        wr_cmp(1'b1, 8'h10);
        run(200, "R4", "R10");
        wr_cmp(1'b1, 8'h30);
        run(200, "R4", "R12");
    endtask

    task automatic t_phase();
        reset_dut(3'd1, 2'b10);
        wr_cmp(1'b1, 8'h80);
        run(1100, "R5", "R11");
        wr_cmp(1'b1, 8'h00);
        run(1100, "R5", "R11");
        wr_cmp(1'b1, 8'hFF);
        run(1100, "R5", "R12");
        com_b = 2'b11;
        wr_cmp(1'b1, 8'h40);
        run(1100, "R5", "R11");
        com_b = 2'b00;
        run(20, "R5", "R13");
        reset_dut(3'd5, 2'b11);
        wr_cmp(1'b0, 8'h20);
        wr_cmp(1'b1, 8'h10);
        run(200, "R5", "R11");
        wr_cmp(1'b1, 8'h20);
        run(200, "R5", "R12");
    endtask

    task automatic t_reserved();
        reset_dut(3'd4, 2'b01);
        wr_cmp(1'b1, 8'h03);
        run(300, "R2", "R9");
        reset_dut(3'd6, 2'b11);
        wr_cmp(1'b1, 8'hF0);
        run(300, "R2", "R9");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_normal();
        t_ctc();
        t_fast();
        t_phase();
        t_reserved();
        finish_run();
    end

endmodule